// File: doc/BRIEF.md
# Video DMA Address Sequencer

This block generates the address stream for the three DMA transfer kinds of a video display controller. The kinds are a copy from the system bus into video memory, a constant-byte fill of video memory, and a byte copy from one part of video memory to another. A controller writes the byte-wide parameter registers (length, a three-byte source and the auto-increment step), sets a destination start address and a target memory, and pulses `start`. The sequencer then emits one transfer descriptor per beat on a valid/ready stream. Each descriptor holds a source address, a destination address, a byte-swap flag and the fill byte. A memory agent downstream performs the actual reads and writes.

The stream follows valid/ready rules. A beat is accepted on a rising clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, the current descriptor is held unchanged and nothing advances. The consumer may apply back-pressure for any number of cycles. `out_valid` never drops while a run is still in progress. All parameters are captured on the `start` cycle, so the register inputs may change freely during a run. When a run ends, the register view shows the length drained to zero and the source registers pointing at the next address, the way a register file updated in place would.

Top module: `vdma_addr_gen`

## Requirements
- R1: After reset, `busy` and `out_valid` are 0, and `reg_len` and `reg_src` are 0.
- R2: A run issues exactly {len_hi,len_lo} beats. A length of 0 issues 65536 beats.
- R3: In bus mode (mode 0), the first source byte address is (src_hi[6:0]<<17) | (src_mid<<9) | (src_lo<<1). It is 24 bits wide and bit 0 is always 0.
- R4: In bus mode, each accepted beat adds 2 to source bits [16:0], wrapping within that 17-bit window. Source bits [23:17] never change during the run.
- R5: In fill mode (mode 1) and copy mode (mode 2 or 3), the source starts at {src_mid,src_lo}, adds 1 per accepted beat, and wraps at 16 bits. Bits [23:16] are 0.
- R6: The destination starts at `dst_start` and adds `auto_inc` (zero-extended) after each accepted beat, wrapping at 16 bits.
- R7: A descriptor advances only on a beat with `out_valid` and `out_ready` both high. While stalled, `out_src`, `out_dst`, `out_swap` and `out_fill` hold their values.
- R8: `busy` rises on the cycle after an accepted `start` and falls on the cycle after the last beat is accepted. `out_valid` equals `busy`.
- R9: A `start` pulse while `busy` is high is ignored: the beat count and the address sequence of the current run are unchanged.
- R10: After a run, `reg_len` reads 0. In bus mode, `reg_src` reads {src_hi[7], next_source[23:1]}. Otherwise it reads {src_hi, next_source[15:0]}.
- R11: `out_swap` is 1 only in bus mode with target VRAM (target 0) when the current destination bit 0 is 1.
- R12: With target VSRAM (target 2), `out_dst` shows only bits [6:1] of the destination (mask 0x007E). Target 0 (VRAM) and target 1 (CRAM) show it unmasked.
- R13: `out_fill` carries the captured fill byte during a fill run and is 0 in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; captured only while idle |
| mode | input | 2 | 0 bus copy, 1 fill, 2 or 3 video-memory copy |
| target | input | 2 | 0 VRAM, 1 CRAM, 2 VSRAM |
| len_lo | input | 8 | Length low byte |
| len_hi | input | 8 | Length high byte |
| src_lo | input | 8 | Source low byte |
| src_mid | input | 8 | Source middle byte |
| src_hi | input | 8 | Source high byte |
| auto_inc | input | 8 | Destination step per beat |
| dst_start | input | 16 | First destination address |
| fill_byte | input | 8 | Fill value |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Consumer accepts descriptor |
| out_src | output | 24 | Source address of current beat |
| out_dst | output | 16 | Destination address of current beat |
| out_swap | output | 1 | Swap the bytes of the word for this beat |
| out_fill | output | 8 | Fill byte for this beat |
| reg_len | output | 16 | Length register view |
| reg_src | output | 24 | Source register view {hi,mid,lo} |

## Verification
The bench targets the following corner cases and the symptom each would show if the design got it wrong:

- **Bus source crossing its 128 KB window.** A design carrying into bit 17 would corrupt the high source bits.
- **Fill and copy source crossing 0xFFFF.** A design that wrapped wrongly would show a non-zero bit 16.
- **Destination wrapping past 0xFFFF.** A step of 0 must repeat one address, and a step of 0xFF is the largest step.
- **Zero length.** A design that used the length verbatim would end after zero beats, or after one beat, instead of 65536.
- **Back-pressure.** A consumer stalling in regular and pseudo-random patterns would expose descriptors that advance without a handshake.
- **`start` pulse mid-run.** A pulse carrying different parameters would expose a design that re-captures them.
- **Odd destinations and the VSRAM mask.** These would expose a swap flag or a mask applied to the wrong target or mode.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int REG_BITS   = 8;
  localparam int LEN_BITS   = 2 * REG_BITS;
  localparam int VADDR_BITS = 2 * REG_BITS;
  localparam int BUS_BITS   = 3 * REG_BITS;
  localparam int WIN_BITS   = 2 * REG_BITS + 1;

  typedef enum logic [1:0] {
    XF_BUS  = 2'd0,
    XF_FILL = 2'd1,
    XF_COPY = 2'd2,
    XF_COPY_ALT = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    TG_VRAM  = 2'd0,
    TG_CRAM  = 2'd1,
    TG_VSRAM = 2'd2,
    TG_NONE  = 2'd3
  } target_e;
endpackage

// File: rtl/vdma_len_ctr.sv
module vdma_len_ctr
  import vdma_pkg::*;
#(
  parameter int LEN_W = LEN_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [LEN_W-1:0] len_in,
  output logic             busy,
  output logic             last,
  output logic [LEN_W-1:0] remain
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      // a zero length means one full wrap of the length field
      cnt_q <= (len_in == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len_in};
    end else if (step && busy) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy   = (cnt_q != '0);
  assign last   = (cnt_q == CNT_W'(1));
  assign remain = cnt_q[LEN_W-1:0];

  AST_LEN_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && busy && !last) |=> (busy && cnt_q == $past(cnt_q) - CNT_W'(1))); // R2
  AST_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (!busy && remain == '0)); // R8
endmodule

// File: rtl/vdma_src_gen.sv
module vdma_src_gen
  import vdma_pkg::*;
#(
  parameter int REG_W = REG_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic               is_bus,
  input  logic [REG_W-1:0]   r_lo,
  input  logic [REG_W-1:0]   r_mid,
  input  logic [REG_W-1:0]   r_hi,
  output logic [3*REG_W-1:0] src,
  output logic [3*REG_W-1:0] image
);
  localparam int AW  = 3 * REG_W;
  localparam int VA  = 2 * REG_W;
  localparam int WIN = 2 * REG_W + 1;

  logic [AW-1:0]    src_q;
  logic [REG_W-1:0] hi_q;
  logic             bus_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      hi_q  <= '0;
      bus_q <= 1'b0;
    end else if (load) begin
      hi_q  <= r_hi;
      bus_q <= is_bus;
      if (is_bus) src_q <= {r_hi[REG_W-2:0], r_mid, r_lo, 1'b0};
      else        src_q <= {{REG_W{1'b0}}, r_mid, r_lo};
    end else if (step) begin
      if (bus_q) src_q <= {src_q[AW-1:WIN], src_q[WIN-1:0] + WIN'(2)};
      else       src_q <= {{REG_W{1'b0}}, src_q[VA-1:0] + VA'(1)};
    end
  end

  assign src   = src_q;
  assign image = bus_q ? {hi_q[REG_W-1], src_q[AW-1:1]} : {hi_q, src_q[VA-1:0]};

  AST_BUS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && bus_q) |=> (src_q[AW-1:WIN] == $past(src_q[AW-1:WIN]) && !src_q[0])); // R4
  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !bus_q) |=> (src_q[VA-1:0] == $past(src_q[VA-1:0]) + VA'(1))); // R5
endmodule

// File: rtl/vdma_dst_gen.sv
module vdma_dst_gen
  import vdma_pkg::*;
#(
  parameter int                   REG_W   = REG_BITS,
  parameter logic [2*REG_W-1:0]   VS_MASK = 'h7E
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic               is_bus,
  input  logic               valid,
  input  logic [1:0]         tgt_in,
  input  logic [2*REG_W-1:0] dst_in,
  input  logic [REG_W-1:0]   inc_in,
  output logic [2*REG_W-1:0] dst_out,
  output logic               swap
);
  localparam int VA = 2 * REG_W;

  logic [VA-1:0]    dst_q;
  logic [REG_W-1:0] inc_q;
  target_e          tgt_q;
  logic             bus_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_q <= '0;
      inc_q <= '0;
      tgt_q <= TG_VRAM;
      bus_q <= 1'b0;
    end else if (load) begin
      dst_q <= dst_in;
      inc_q <= inc_in;
      tgt_q <= target_e'(tgt_in);
      bus_q <= is_bus;
    end else if (step) begin
      dst_q <= dst_q + {{REG_W{1'b0}}, inc_q};
    end
  end

  assign dst_out = (tgt_q == TG_VSRAM) ? (dst_q & VS_MASK) : dst_q;
  assign swap    = valid && bus_q && (tgt_q == TG_VRAM) && dst_q[0];

  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (dst_q == $past(dst_q) + {{REG_W{1'b0}}, $past(inc_q)})); // R6
  AST_VSRAM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && tgt_q == TG_VSRAM) |-> (dst_out[0] == 1'b0 && dst_out[VA-1:7] == '0)); // R12
endmodule

// File: rtl/vdma_addr_gen.sv
module vdma_addr_gen
  import vdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic [1:0]  target,
  input  logic [7:0]  len_lo,
  input  logic [7:0]  len_hi,
  input  logic [7:0]  src_lo,
  input  logic [7:0]  src_mid,
  input  logic [7:0]  src_hi,
  input  logic [7:0]  auto_inc,
  input  logic [15:0] dst_start,
  input  logic [7:0]  fill_byte,
  output logic        busy,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [23:0] out_src,
  output logic [15:0] out_dst,
  output logic        out_swap,
  output logic [7:0]  out_fill,
  output logic [15:0] reg_len,
  output logic [23:0] reg_src
);
  logic       load, step, last, bus_in;
  xfer_mode_e mode_q;
  logic [7:0] fill_q;

  assign load   = start && !busy;
  assign step   = busy && out_ready;
  assign bus_in = (xfer_mode_e'(mode) == XF_BUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= XF_BUS;
      fill_q <= '0;
    end else if (load) begin
      mode_q <= xfer_mode_e'(mode);
      fill_q <= fill_byte;
    end
  end

  vdma_len_ctr #(.LEN_W(LEN_BITS)) u_len (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .len_in({len_hi, len_lo}), .busy(busy), .last(last), .remain(reg_len)
  );

  vdma_src_gen #(.REG_W(REG_BITS)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .is_bus(bus_in),
    .r_lo(src_lo), .r_mid(src_mid), .r_hi(src_hi), .src(out_src), .image(reg_src)
  );

  vdma_dst_gen #(.REG_W(REG_BITS)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .is_bus(bus_in),
    .valid(busy), .tgt_in(target), .dst_in(dst_start), .inc_in(auto_inc),
    .dst_out(out_dst), .swap(out_swap)
  );

  assign out_valid = busy;
  assign out_fill  = (busy && mode_q == XF_FILL) ? fill_q : 8'h00;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_src) && $stable(out_dst)
                                   && $stable(out_swap) && $stable(out_fill))); // R7
  AST_LAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && last) |=> !out_valid); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !out_ready) |=> $stable(reg_len)); // R9
endmodule

// File: tb/test_vdma_addr_gen.sv
`timescale 1ns/1ps
module test_vdma_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0, target = '0;
  logic [7:0]  len_lo = '0, len_hi = '0, src_lo = '0, src_mid = '0, src_hi = '0;
  logic [7:0]  auto_inc = '0, fill_byte = '0;
  logic [15:0] dst_start = '0;
  logic        out_ready = 1'b0;
  logic        busy, out_valid, out_swap;
  logic [23:0] out_src, reg_src;
  logic [15:0] out_dst, reg_len;
  logic [7:0]  out_fill;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  vdma_addr_gen i_vdma_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .target(target),
    .len_lo(len_lo), .len_hi(len_hi), .src_lo(src_lo), .src_mid(src_mid),
    .src_hi(src_hi), .auto_inc(auto_inc), .dst_start(dst_start),
    .fill_byte(fill_byte), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_src(out_src), .out_dst(out_dst),
    .out_swap(out_swap), .out_fill(out_fill), .reg_len(reg_len), .reg_src(reg_src)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish (actual cycles %0d expected < 190000)", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // stall: 0 always ready, 1 every third cycle low, 2 pseudo-random
  task automatic run(input int md, input int tg, input int len, input int lo, input int mid,
                     input int hi, input int inc, input int dst, input int fb,
                     input int stall, input bit poke);
    logic [31:0] esrc, edst, eimg, eo_dst;
    int n_exp, n_got, k;
    bit esw;
    @(negedge clk);
    mode = md[1:0]; target = tg[1:0];
    len_lo = len[7:0]; len_hi = len[15:8];
    src_lo = lo[7:0]; src_mid = mid[7:0]; src_hi = hi[7:0];
    auto_inc = inc[7:0]; dst_start = dst[15:0]; fill_byte = fb[7:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_exp = (len == 0) ? 65536 : len;
    if (md == 0) esrc = ((hi & 32'h7F) << 17) | (mid << 9) | (lo << 1); // R3
    else         esrc = (mid << 8) | lo;                               // R5
    edst = dst;
    n_got = 0;
    k = 0;
    chk(busy == 1'b1, "R8 busy after start", {31'b0, busy}, 1);
    while (out_valid) begin
      if (poke && k == 1) begin
        start = 1'b1; len_lo = 8'h01; len_hi = 8'h00; src_lo = 8'h00; src_mid = 8'h00;
        auto_inc = 8'h07; dst_start = 16'h1234; mode = 2'd1;
      end else begin
        start = 1'b0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (stall)
        0: out_ready = 1'b1;
        1: out_ready = (k % 3) != 2;
        default: out_ready = lfsr[0];
      endcase
      eo_dst = (tg == 2) ? (edst & 32'h7E) : edst;
      esw = (md == 0) && (tg == 0) && edst[0];
      chk(out_src == esrc[23:0], (md == 0) ? "R4 bus source" : "R5 byte source", {8'b0, out_src}, esrc);
      chk(out_dst == eo_dst[15:0], (tg == 2) ? "R12 vsram dst" : "R6 dst", {16'b0, out_dst}, eo_dst);
      chk(out_swap == esw, "R11 swap", {31'b0, out_swap}, {31'b0, esw});
      chk(out_fill == ((md == 1) ? fb[7:0] : 8'h00), "R13 fill byte", {24'b0, out_fill},
          (md == 1) ? (fb & 32'hFF) : 0);
      if (out_ready) begin
        n_got = n_got + 1;
        if (md == 0) esrc = (esrc & 32'hFE0000) | ((esrc + 2) & 32'h1FFFF);
        else         esrc = (esrc + 1) & 32'hFFFF;
        edst = (edst + inc) & 32'hFFFF;
      end
      k = k + 1;
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    eimg = (md == 0) ? (((hi & 32'h80) << 16) | (esrc >> 1)) : (((hi & 32'hFF) << 16) | esrc);
    chk(n_got == n_exp, poke ? "R9 count with mid-run start" : "R2 beat count", n_got, n_exp);
    chk(busy == 1'b0 && out_valid == 1'b0, "R8 idle after run", {30'b0, busy, out_valid}, 0);
    chk(reg_len == 16'h0, "R10 length view", {16'b0, reg_len}, 0);
    chk(reg_src == eimg[23:0], "R10 source view", {8'b0, reg_src}, eimg);
    // idle: outputs stay quiet for a cycle
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 stays idle", {31'b0, out_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R1 reset control", {30'b0, busy, out_valid}, 0);
    chk(reg_len == 16'h0 && reg_src == 24'h0, "R1 reset views", {8'b0, reg_src}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 idle after reset", {31'b0, busy}, 0);

    // bus copy crossing the 17-bit window, odd destinations, hi bit 7 set
    run(0, 0, 6, 8'hFE, 8'hFF, 8'hC5, 3, 16'h0101, 8'h5A, 0, 1'b0);
    // bus copy to VSRAM with regular stalls
    run(0, 2, 5, 8'h10, 8'h02, 8'h01, 8'h22, 16'h00F3, 0, 1, 1'b0);
    // fill wrapping destination, random stalls
    run(1, 0, 7, 8'h34, 8'h12, 8'h9E, 1, 16'hFFFE, 8'hA5, 2, 1'b0);
    // copy with source wrap at 0xFFFF, mid-run start pokes (R9)
    run(2, 1, 5, 8'hFD, 8'hFF, 8'h03, 8'h80, 16'h4000, 0, 2, 1'b1);
    // mode 3 acts as copy
    run(3, 0, 3, 8'h00, 8'h80, 8'h00, 2, 16'h0003, 8'h11, 0, 1'b0);

    // near-exhaustive sweep over small lengths and edge steps
    for (int m = 0; m < 3; m++) begin
      for (int l = 1; l <= 3; l++) begin
        for (int s = 0; s < 4; s++) begin
          int incv;
          incv = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 2 : 255;
          run(m, (l + s) % 3, l, 8'hFF - l, 8'hFF, 8'h7F, incv, 16'hFFFF - s, 8'h3C + l,
              (m + l) % 3, 1'b0);
        end
      end
    end

    // zero length means 65536 beats
    run(2, 0, 0, 8'h00, 8'h00, 8'h00, 2, 16'h0000, 0, 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule